// File: doc/BRIEF.md
# Ping-Pong Sample Buffer Writer

This block is a small transfer engine that fills a circular sample buffer in on-chip memory. Each request pulse reads a pair of adjacent 32-bit source words through a simple read port. The read address always starts again at the same source base, so the engine keeps sampling a fixed two-word window. It then writes both words to consecutive destination locations. The destination offset moves forward by one word per write. When the last pair of the buffer has been stored, a negative adjustment of one buffer length brings the offset back to the buffer start.

The buffer is meant to be used in two halves. One interrupt flag rises when the first half has been filled, and a second flag rises when the whole buffer has been filled. A separate output tells a consumer which half it may drain: the half that the writer is not currently filling. A request that arrives while a transfer is running waits in a single slot. A request that finds the slot already full is lost and sets a sticky error flag.

Top module: `ping_pong_writer`

## Requirements
- R1: Each accepted request issues exactly two source reads, the first at SRC_BASE and the second at SRC_BASE+4, on consecutive cycles. The source returns read data in the cycle after the cycle in which src_rd is high.
- R2: The two words of a request are written on consecutive cycles, the word read from SRC_BASE first. Each write goes to the address 4 bytes above the previous write.
- R3: After BUF_BYTES/8 requests have been written, the next write goes to DST_BASE again, so write k lands at DST_BASE + 4*(k mod BUF_BYTES/4).
- R4: flag_half becomes 1 in the same cycle as the second write of the (BUF_BYTES/16)-th request of each pass through the buffer.
- R5: flag_full becomes 1 in the same cycle as the second write of the last request of each pass through the buffer. The pass count then starts over.
- R6: Both flags stay 1 until irq_clr is sampled high, which clears both. If a flag is set on the same edge that irq_clr is high, the flag ends up set.
- R7: drain_upper is 1 while the next destination offset lies in the lower half of the buffer, and 0 while it lies in the upper half.
- R8: A request sampled while the engine is idle is accepted on that edge. The engine is then busy for the following three edges. A request sampled while busy is held in a one-deep slot and starts on the first idle edge.
- R9: A request sampled while busy with the slot already occupied is dropped (it causes no writes) and sets err_drop. err_drop stays 1 until reset.
- R10: While rst is high and after it is released: wr_en=0, src_rd=0, flag_half=0, flag_full=0, err_drop=0 and drain_upper=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request strobe, one pair per sampled high cycle |
| irq_clr | input | 1 | Clears both interrupt flags |
| src_rd | output | 1 | Source read strobe |
| src_addr | output | ADDR_W | Source byte address |
| src_rdata | input | DATA_W | Source read data, valid one cycle after src_rd |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | ADDR_W | Destination byte address |
| wr_data | output | DATA_W | Destination write data |
| flag_half | output | 1 | First half of the buffer filled |
| flag_full | output | 1 | Whole buffer filled |
| drain_upper | output | 1 | 1: consumer may read the upper half; 0: the lower half |
| err_drop | output | 1 | Sticky: a request was dropped |

## Verification
Isolated requests show the basic read-then-write sequence and the pointer step. Pairs of requests on adjacent cycles show that the second request is queued rather than lost. Runs of three adjacent requests show that exactly one request is dropped and that the error flag latches. Randomly spaced requests over several passes through the buffer show that wrap-around, the half and full flag timing, and the drain side agree with a model built only from the write count. A clear pulse placed on the edge where the half flag is set shows that the set takes priority.

// File: rtl/pbw_pkg.sv
`timescale 1ns/1ps
package pbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD0  = 2'd1,
    ST_RD1  = 2'd2,
    ST_LAST = 2'd3
  } pbw_state_e;
endpackage

// File: rtl/pbw_req_slot.sv
`timescale 1ns/1ps
// One-deep request holding slot with sticky drop detection.
module pbw_req_slot (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic busy,
  output logic pend,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      err  <= 1'b0;
    end else if (busy) begin
      if (req) begin
        if (pend) err  <= 1'b1;
        else      pend <= 1'b1;
      end
    end else if (pend) begin
      // held request starts now; a fresh one refills the slot
      pend <= req;
    end
  end
endmodule

// File: rtl/pbw_major_ctr.sv
`timescale 1ns/1ps
// Counts completed pairs down from the pass length and raises the half/full flags.
module pbw_major_ctr #(
  parameter int unsigned MAJOR = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic minor_done,
  input  logic irq_clr,
  output logic last_pair,
  output logic flag_half,
  output logic flag_full
);
  localparam int unsigned CW   = $clog2(MAJOR + 1);
  localparam int unsigned HALF = MAJOR / 2;

  logic [CW-1:0] cnt;

  assign last_pair = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= CW'(MAJOR);
      flag_half <= 1'b0;
      flag_full <= 1'b0;
    end else begin
      if (irq_clr) begin
        flag_half <= 1'b0;
        flag_full <= 1'b0;
      end
      if (minor_done) begin
        if (last_pair) begin
          cnt       <= CW'(MAJOR);
          flag_full <= 1'b1;
        end else begin
          cnt <= cnt - CW'(1);
          if (cnt == CW'(HALF + 1)) flag_half <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pbw_dst_ptr.sv
`timescale 1ns/1ps
// Destination offset: word step, negative buffer-length adjust at pass end.
module pbw_dst_ptr #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned BUF_BYTES  = 64,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              wrap,
  output logic [ADDR_W-1:0] off,
  output logic              drain_upper
);
  localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] BUF_B  = ADDR_W'(BUF_BYTES);
  localparam logic [ADDR_W-1:0] HALF_B = ADDR_W'(BUF_BYTES / 2);

  logic [ADDR_W-1:0] off_nxt;

  always_comb begin
    off_nxt = off + STEP_B;
    if (wrap) off_nxt = off + STEP_B - BUF_B;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off         <= '0;
      drain_upper <= 1'b1;
    end else if (step) begin
      off         <= off_nxt;
      drain_upper <= (off_nxt < HALF_B);
    end
  end
endmodule

// File: rtl/ping_pong_writer.sv
`timescale 1ns/1ps
module ping_pong_writer #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SRC_BASE  = 32'h0100,
  parameter int unsigned DST_BASE  = 32'h0800,
  parameter int unsigned BUF_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              irq_clr,
  output logic              src_rd,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_rdata,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              flag_half,
  output logic              flag_full,
  output logic              drain_upper,
  output logic              err_drop
);
  import pbw_pkg::*;

  localparam int unsigned WORD_BYTES  = DATA_W / 8;
  localparam int unsigned MINOR_BYTES = 2 * WORD_BYTES;
  localparam int unsigned MAJOR       = BUF_BYTES / MINOR_BYTES;
  localparam logic [ADDR_W-1:0] SRC0  = ADDR_W'(SRC_BASE);
  localparam logic [ADDR_W-1:0] SRC1  = ADDR_W'(SRC_BASE + WORD_BYTES);
  localparam logic [ADDR_W-1:0] DST0  = ADDR_W'(DST_BASE);

  pbw_state_e        state;
  logic              busy, pend, start, step, minor_done, last_pair;
  logic [ADDR_W-1:0] off;

  assign busy       = (state != ST_IDLE);
  assign start      = !busy && (req || pend);
  assign step       = (state == ST_RD1) || (state == ST_LAST);
  assign minor_done = (state == ST_LAST);

  pbw_req_slot u_slot (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .busy (busy),
    .pend (pend),
    .err  (err_drop)
  );

  pbw_major_ctr #(.MAJOR(MAJOR)) u_major (
    .clk        (clk),
    .rst        (rst),
    .minor_done (minor_done),
    .irq_clr    (irq_clr),
    .last_pair  (last_pair),
    .flag_half  (flag_half),
    .flag_full  (flag_full)
  );

  pbw_dst_ptr #(
    .ADDR_W     (ADDR_W),
    .BUF_BYTES  (BUF_BYTES),
    .WORD_BYTES (WORD_BYTES)
  ) u_dst (
    .clk         (clk),
    .rst         (rst),
    .step        (step),
    .wrap        (minor_done && last_pair),
    .off         (off),
    .drain_upper (drain_upper)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      src_rd   <= 1'b0;
      src_addr <= SRC0;
      wr_en    <= 1'b0;
      wr_addr  <= DST0;
      wr_data  <= '0;
    end else begin
      src_rd <= 1'b0;
      wr_en  <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_RD0;
          src_rd   <= 1'b1;
          src_addr <= SRC0;
        end
        ST_RD0: begin
          state    <= ST_RD1;
          src_rd   <= 1'b1;
          src_addr <= SRC1;
        end
        ST_RD1: begin
          state   <= ST_LAST;
          wr_en   <= 1'b1;
          wr_addr <= DST0 + off;
          wr_data <= src_rdata;
        end
        default: begin
          state   <= ST_IDLE;
          wr_en   <= 1'b1;
          wr_addr <= DST0 + off;
          wr_data <= src_rdata;
        end
      endcase
    end
  end
endmodule

// File: rtl/pbw_checker.sv
`timescale 1ns/1ps
module pbw_checker #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SRC_BASE  = 32'h0100,
  parameter int unsigned DST_BASE  = 32'h0800,
  parameter int unsigned BUF_BYTES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_clr,
  input logic              src_rd,
  input logic [ADDR_W-1:0] src_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              flag_half,
  input logic              flag_full,
  input logic              err_drop
);
  localparam logic [ADDR_W-1:0] S0 = ADDR_W'(SRC_BASE);
  localparam logic [ADDR_W-1:0] S1 = ADDR_W'(SRC_BASE + 4);
  localparam logic [ADDR_W-1:0] D0 = ADDR_W'(DST_BASE);
  localparam logic [ADDR_W-1:0] DL = ADDR_W'(DST_BASE + BUF_BYTES - 4);

  AST_SRC_WINDOW: assert property (@(posedge clk) disable iff (rst)
    src_rd |-> (src_addr == S0 || src_addr == S1)); // R1
  AST_SRC_ORDER: assert property (@(posedge clk) disable iff (rst)
    (src_rd && $past(src_rd)) |-> (src_addr == S1 && $past(src_addr) == S0)); // R1
  AST_DST_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + ADDR_W'(4)); // R2
  AST_DST_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr >= D0 && wr_addr <= DL)); // R3
  AST_HALF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_half) && !$past(irq_clr)) |-> flag_half); // R6
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_full) && !$past(irq_clr)) |-> flag_full); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(err_drop) |-> err_drop); // R9
endmodule

bind ping_pong_writer pbw_checker #(
  .ADDR_W    (ADDR_W),
  .SRC_BASE  (SRC_BASE),
  .DST_BASE  (DST_BASE),
  .BUF_BYTES (BUF_BYTES)
) u_pbw_checker (
  .clk       (clk),
  .rst       (rst),
  .irq_clr   (irq_clr),
  .src_rd    (src_rd),
  .src_addr  (src_addr),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .flag_half (flag_half),
  .flag_full (flag_full),
  .err_drop  (err_drop)
);

// File: tb/ping_pong_writer_test.sv
`timescale 1ns/1ps
module ping_pong_writer_test;
  localparam int unsigned SRC_BASE  = 32'h0100;
  localparam int unsigned DST_BASE  = 32'h0800;
  localparam int unsigned BUF_BYTES = 64;
  localparam int unsigned WPB       = BUF_BYTES / 4;   // words per buffer
  localparam int unsigned MAJOR     = BUF_BYTES / 8;
  localparam int unsigned HALF      = MAJOR / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        irq_clr = 1'b0;
  logic        src_rd;
  logic [15:0] src_addr;
  logic [31:0] src_rdata = '0;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        flag_half, flag_full, drain_upper, err_drop;

  int tests = 0;
  int fails = 0;
  int rd_idx = 0;
  int rd_chk = 0;
  int wr_k = 0;
  int accepted = 0;
  bit exp_half = 0, exp_full = 0, exp_drain = 1;
  bit clr_edge = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ping_pong_writer #(
    .SRC_BASE(SRC_BASE), .DST_BASE(DST_BASE), .BUF_BYTES(BUF_BYTES)
  ) uut (
    .clk(clk), .rst(rst), .req(req), .irq_clr(irq_clr),
    .src_rd(src_rd), .src_addr(src_addr), .src_rdata(src_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_half(flag_half), .flag_full(flag_full),
    .drain_upper(drain_upper), .err_drop(err_drop)
  );

  function automatic logic [31:0] mk(int k, logic [15:0] a);
    return (32'(k) * 32'h9E37_79B1) ^ {16'hC3A5, a};
  endfunction

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // source register window: data appears the cycle after src_rd
  always @(posedge clk) begin
    clr_edge <= irq_clr;
    if (src_rd) begin
      src_rdata <= mk(rd_idx, src_addr);
      rd_idx    <= rd_idx + 1;
    end
  end

  // monitor with reference model driven by the write count
  always @(negedge clk) begin
    if (!rst) begin
      if (src_rd) begin
        chk(src_addr == 16'(SRC_BASE + 4 * (rd_chk % 2)), "R1 src_addr",
            32'(src_addr), SRC_BASE + 4 * (rd_chk % 2));
        rd_chk++;
      end
      if (clr_edge) begin
        exp_half = 0;
        exp_full = 0;
      end
      if (wr_en) begin
        chk(wr_addr == 16'(DST_BASE + 4 * (wr_k % WPB)),
            (wr_k % WPB == 0) ? "R3 wrap addr" : "R2 dst addr",
            32'(wr_addr), DST_BASE + 4 * (wr_k % WPB));
        chk(wr_data == mk(wr_k, 16'(SRC_BASE + 4 * (wr_k % 2))), "R2 data order",
            wr_data, mk(wr_k, 16'(SRC_BASE + 4 * (wr_k % 2))));
        if (wr_k % 2 == 1) begin
          if (((wr_k + 1) / 2) % MAJOR == HALF) exp_half = 1;
          if (((wr_k + 1) / 2) % MAJOR == 0)    exp_full = 1;
        end
        wr_k++;
        exp_drain = (4 * (wr_k % WPB)) < (BUF_BYTES / 2);
        chk(drain_upper == exp_drain, "R7 drain side", 32'(drain_upper), 32'(exp_drain));
      end
      if (wr_en || clr_edge) begin
        chk(flag_half == exp_half, "R4 flag_half", 32'(flag_half), 32'(exp_half));
        chk(flag_full == exp_full, "R5 flag_full", 32'(flag_full), 32'(exp_full));
      end
    end
  end

  task automatic pulse_req(int n);
    @(negedge clk) req = 1'b1;
    repeat (n) @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    @(negedge clk);
    chk(!flag_half && !flag_full, "R6 clear", {flag_half, flag_full}, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!wr_en && !src_rd, "R10 strobes in reset", {wr_en, src_rd}, 0);
    chk(!flag_half && !flag_full && !err_drop, "R10 flags in reset",
        {flag_half, flag_full, err_drop}, 0);
    chk(drain_upper == 1'b1, "R10 drain in reset", 32'(drain_upper), 1);
    rst = 1'b0;
    idle(2);
    chk(!wr_en && !src_rd && drain_upper, "R10 after release", {wr_en, src_rd, drain_upper}, 1);

    // R8: isolated request
    pulse_req(1); accepted += 1; idle(8);
    chk(wr_k == 2, "R8 single request", wr_k, 2);

    // R8: two adjacent requests, second queued
    pulse_req(2); accepted += 2; idle(12);
    chk(wr_k == 6, "R8 queued request", wr_k, 6);
    chk(err_drop == 1'b0, "R8 no drop", 32'(err_drop), 0);

    // R9: three adjacent requests, third dropped
    pulse_req(3); accepted += 2; idle(12);
    chk(wr_k == 10, "R9 dropped request", wr_k, 10);
    chk(err_drop == 1'b1, "R9 err set", 32'(err_drop), 1);

    // random spacing across several passes
    for (int i = 0; i < 60; i++) begin
      pulse_req(1); accepted += 1;
      idle(4 + ($urandom % 8));
      if ($urandom % 9 == 0) begin
        idle(4);
        clear_flags();
      end
    end
    idle(8);
    chk(wr_k == 2 * accepted, "R8 write total", wr_k, 2 * accepted);
    chk(err_drop == 1'b1, "R9 err sticky", 32'(err_drop), 1);

    // R6: clear on the same edge as the half flag set; set wins
    while ((wr_k / 2) % MAJOR != HALF - 1) begin
      pulse_req(1); accepted += 1; idle(6);
    end
    clear_flags();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    accepted += 1;
    @(negedge clk);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    idle(2);
    chk(flag_half == 1'b1, "R6 set wins over clear", 32'(flag_half), 1);
    chk(wr_k == 2 * accepted, "R4 final count", wr_k, 2 * accepted);

    done = 1;
    report();
  end
endmodule